// File: doc/BRIEF.md
# Radio Operating-Mode Sequencer

This block is the mode controller of a 2.4 GHz transceiver. Decoded command strobes arrive on a small code bus, qualified by a valid bit. The block walks the radio through six modes: fully powered down, oscillator running with the radio idle, synthesizer calibrating, synthesizer locked and waiting, receiving, and transmitting. Its outputs are the enables that the receive chain, the transmit chain and the synthesizer read. It also drives the power-down controls of the crystal oscillator and of the bias generator.

A transmit strobe recalibrates the synthesizer only when no valid calibration is held. A second transmit strobe acts only when the channel assessment input reports a clear channel. When a transmission ends, the radio goes back to receive if it was receiving when the transmission began, and to the synthesizer wait mode otherwise. The block also issues one-cycle flush pulses for the two FIFOs and one-cycle acknowledge-frame requests that carry the frame-pending bit. It gates FIFO reads and writes on the oscillator being up, and it raises a sticky error flag when an access is attempted while the oscillator is down.

Top module: `radio_mode_fsm`

## Requirements
- R1: After reset, `mode` is 0 (powered down), `xosc_pd` and `bias_pd` are 1, and `rx_en`, `tx_en`, `synth_en`, `cal_valid`, `fifo_err`, the flush pulses and `ack_req` are 0. The mode codes are 0 down, 1 idle, 2 calibrating, 3 synthesizer wait, 4 receive and 5 transmit.
- R2: The strobe codes are 0 no-op, 1 oscillator on, 2 calibrate, 3 receive on, 4 transmit, 5 transmit-if-clear, 6 RF off, 7 oscillator off, 8 flush RX, 9 flush TX, 10 ack, 11 ack-pending. Any other code has no effect. In mode 0, strobe 1 moves the block to idle one cycle after the strobe and clears `xosc_pd` and `bias_pd`. Every other strobe has no effect in mode 0.
- R3: Strobe 2, given in idle, wait, receive or transmit, enters calibration for exactly CAL_CYCLES cycles. The block then goes to the wait mode, where `synth_en` is 1 and `rx_en` and `tx_en` are 0, and sets `cal_valid`.
- R4: Strobe 3, given in idle or wait, enters receive one cycle later, with `rx_en` and `synth_en` set. In other modes it has no effect.
- R5: Strobe 4, given in idle, wait or receive, enters transmit one cycle later if `cal_valid` is 1. If `cal_valid` is 0, it first calibrates for CAL_CYCLES cycles and then enters transmit with `cal_valid` set.
- R6: Strobe 5 behaves as strobe 4 when `cca_clear` is 1 in the strobe cycle, and otherwise has no effect.
- R7: `tx_done` in transmit returns the block to receive if the transmit strobe was given in receive, and to wait otherwise.
- R8: Strobe 6, given in any powered mode, goes to idle. Strobe 7 goes to mode 0 and sets both power-down controls. Both strobes clear `cal_valid`.
- R9: Strobes 8 and 9 give a one-cycle pulse on `flush_rx` or `flush_tx` in the cycle after the strobe, in powered modes only.
- R10: Strobes 10 and 11 give a one-cycle `ack_req` in the cycle after the strobe. `ack_pend` is 0 for strobe 10 and 1 for strobe 11. Neither strobe has any effect in mode 0.
- R11: `fifo_wr_ok` and `fifo_rd_ok` pass `fifo_wr` and `fifo_rd` through in the same cycle only while the oscillator is on. An access attempted while the oscillator is off sets `fifo_err` from the next cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Strobe valid |
| cmd_code | input | 4 | Strobe code |
| cca_clear | input | 1 | Channel assessment reports clear |
| tx_done | input | 1 | Transmission finished |
| fifo_wr | input | 1 | FIFO write attempt |
| fifo_rd | input | 1 | FIFO read attempt |
| mode | output | 3 | Current mode code |
| rx_en | output | 1 | Receive chain enable |
| tx_en | output | 1 | Transmit chain enable |
| synth_en | output | 1 | Synthesizer enable |
| xosc_pd | output | 1 | Crystal oscillator power-down |
| bias_pd | output | 1 | Bias generator power-down |
| cal_valid | output | 1 | Synthesizer calibration held |
| flush_rx | output | 1 | RX FIFO flush and demodulator reset pulse |
| flush_tx | output | 1 | TX FIFO flush pulse |
| ack_req | output | 1 | Acknowledge frame request pulse |
| ack_pend | output | 1 | Pending bit for the requested acknowledge |
| fifo_wr_ok | output | 1 | Gated FIFO write |
| fifo_rd_ok | output | 1 | Gated FIFO read |
| fifo_err | output | 1 | Sticky FIFO access error |

## Verification
A strobe, `tx_done` or a FIFO access takes effect on the first clock edge that samples it. Mode changes, flush pulses, acknowledge requests and `fifo_err` are therefore read on the falling edge that follows. The only exception is the calibration dwell, which ends CAL_CYCLES edges after the strobe. The FIFO gates are combinational, so they are read a short delay after the access is driven, before any edge. The vector table holds a wait count for each row, so a multi-cycle row is sampled one edge before the calibration ends (still calibrating) and again at the edge where it ends (the target mode is reached).

// File: rtl/radio_mode_fsm.sv
module radio_mode_fsm #(
  parameter int CAL_CYCLES = 12,
  parameter int CMD_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             cca_clear,
  input  logic             tx_done,
  input  logic             fifo_wr,
  input  logic             fifo_rd,
  output logic [2:0]       mode,
  output logic             rx_en,
  output logic             tx_en,
  output logic             synth_en,
  output logic             xosc_pd,
  output logic             bias_pd,
  output logic             cal_valid,
  output logic             flush_rx,
  output logic             flush_tx,
  output logic             ack_req,
  output logic             ack_pend,
  output logic             fifo_wr_ok,
  output logic             fifo_rd_ok,
  output logic             fifo_err
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CAL_CYCLES - 1);

  localparam logic [2:0] M_OFF = 3'd0, M_IDLE = 3'd1, M_CAL = 3'd2,
                         M_WAIT = 3'd3, M_RX = 3'd4, M_TX = 3'd5;

  localparam logic [CMD_W-1:0] C_OSCON = 1, C_CAL = 2, C_RXON = 3, C_TXON = 4,
                               C_TXCCA = 5, C_RFOFF = 6, C_OSCOFF = 7,
                               C_FRX = 8, C_FTX = 9, C_ACK = 10, C_ACKP = 11;

  logic [2:0]    st, st_n, tgt, tgt_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          cal_n, ret_rx, ret_n;
  logic          live, tx_ok, go_tx;

  assign live  = cmd_vld && (st != M_OFF);
  assign tx_ok = (st == M_IDLE) || (st == M_WAIT) || (st == M_RX);
  assign go_tx = live && tx_ok &&
                 ((cmd_code == C_TXON) || ((cmd_code == C_TXCCA) && cca_clear));

  always_comb begin
    st_n  = st;
    tgt_n = tgt;
    cnt_n = cnt;
    cal_n = cal_valid;
    ret_n = ret_rx;
    case (st)
      M_OFF: if (cmd_vld && cmd_code == C_OSCON) st_n = M_IDLE;
      M_CAL: begin
        if (cnt == CNT_LAST) begin
          st_n  = tgt;
          cal_n = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      M_TX: if (tx_done) st_n = ret_rx ? M_RX : M_WAIT;
      default: ;
    endcase
    if (go_tx) begin
      ret_n = (st == M_RX);
      if (cal_valid) begin
        st_n = M_TX;
      end else begin
        st_n  = M_CAL;
        tgt_n = M_TX;
        cnt_n = '0;
      end
    end else if (live) begin
      case (cmd_code)
        C_CAL: if (st != M_CAL) begin
          st_n  = M_CAL;
          tgt_n = M_WAIT;
          cnt_n = '0;
        end
        C_RXON: if (st == M_IDLE || st == M_WAIT) st_n = M_RX;
        C_RFOFF: begin
          st_n  = M_IDLE;
          cal_n = 1'b0;
        end
        C_OSCOFF: begin
          st_n  = M_OFF;
          cal_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_OFF;
      tgt       <= M_WAIT;
      cnt       <= '0;
      cal_valid <= 1'b0;
      ret_rx    <= 1'b0;
      flush_rx  <= 1'b0;
      flush_tx  <= 1'b0;
      ack_req   <= 1'b0;
      ack_pend  <= 1'b0;
      fifo_err  <= 1'b0;
    end else begin
      st        <= st_n;
      tgt       <= tgt_n;
      cnt       <= cnt_n;
      cal_valid <= cal_n;
      ret_rx    <= ret_n;
      flush_rx  <= live && (cmd_code == C_FRX);
      flush_tx  <= live && (cmd_code == C_FTX);
      ack_req   <= live && ((cmd_code == C_ACK) || (cmd_code == C_ACKP));
      ack_pend  <= live && (cmd_code == C_ACKP);
      fifo_err  <= fifo_err || ((fifo_wr || fifo_rd) && (st == M_OFF));
    end
  end

  assign mode       = st;
  assign rx_en      = (st == M_RX);
  assign tx_en      = (st == M_TX);
  assign synth_en   = (st == M_CAL) || (st == M_WAIT) || rx_en || tx_en;
  assign xosc_pd    = (st == M_OFF);
  assign bias_pd    = (st == M_OFF);
  assign fifo_wr_ok = fifo_wr && (st != M_OFF);
  assign fifo_rd_ok = fifo_rd && (st != M_OFF);
endmodule

// File: rtl/radio_mode_fsm_chk.sv
module radio_mode_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_vld,
  input logic [3:0] cmd_code,
  input logic       fifo_wr,
  input logic       fifo_rd,
  input logic [2:0] mode,
  input logic       tx_en,
  input logic       xosc_pd,
  input logic       cal_valid,
  input logic       flush_rx,
  input logic       ack_req,
  input logic       ack_pend,
  input logic       fifo_err
);
  // R8
  osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code == 4'd7) |=> (mode == 3'd0 && xosc_pd && !cal_valid));
  // R5
  tx_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> cal_valid);
  // R3
  cal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_valid) |-> $past(mode) == 3'd2);
  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx |-> ($past(cmd_vld) && $past(cmd_code) == 4'd8));
  // R10
  ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (ack_pend == ($past(cmd_code) == 4'd11)));
  // R11
  fifo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_wr || fifo_rd) && xosc_pd) |=> fifo_err);
endmodule

bind radio_mode_fsm radio_mode_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
  .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .mode(mode), .tx_en(tx_en),
  .xosc_pd(xosc_pd), .cal_valid(cal_valid), .flush_rx(flush_rx),
  .ack_req(ack_req), .ack_pend(ack_pend), .fifo_err(fifo_err)
);

// File: tb/test_radio_mode_fsm.sv
module test_radio_mode_fsm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_vld = 1'b0, cca_clear = 1'b0, tx_done = 1'b0;
  logic fifo_wr = 1'b0, fifo_rd = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [2:0] mode;
  logic rx_en, tx_en, synth_en, xosc_pd, bias_pd, cal_valid;
  logic flush_rx, flush_tx, ack_req, ack_pend, fifo_wr_ok, fifo_rd_ok, fifo_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  radio_mode_fsm i_radio_mode_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cca_clear(cca_clear), .tx_done(tx_done), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .mode(mode), .rx_en(rx_en), .tx_en(tx_en), .synth_en(synth_en),
    .xosc_pd(xosc_pd), .bias_pd(bias_pd), .cal_valid(cal_valid),
    .flush_rx(flush_rx), .flush_tx(flush_tx), .ack_req(ack_req), .ack_pend(ack_pend),
    .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok), .fifo_err(fifo_err)
  );

  // {cmd[13:10], cca[9], done[8], extra_wait[7:4], exp_mode[3:1], exp_cal[0]}
  localparam int NV = 18;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 4'd0,  3'd1, 1'b0},  // R2 osc on
    {4'd3,  1'b0, 1'b0, 4'd0,  3'd4, 1'b0},  // R4 rx on
    {4'd4,  1'b0, 1'b0, 4'd0,  3'd2, 1'b0},  // R5 tx without cal -> cal
    {4'd0,  1'b0, 1'b0, 4'd10, 3'd2, 1'b0},  // R5 still calibrating at edge 11
    {4'd0,  1'b0, 1'b0, 4'd0,  3'd5, 1'b1},  // R5 transmit at edge 12
    {4'd0,  1'b0, 1'b1, 4'd0,  3'd4, 1'b1},  // R7 back to rx
    {4'd5,  1'b0, 1'b0, 4'd0,  3'd4, 1'b1},  // R6 busy channel ignored
    {4'd5,  1'b1, 1'b0, 4'd0,  3'd5, 1'b1},  // R6 clear channel, cal held
    {4'd0,  1'b0, 1'b1, 4'd0,  3'd4, 1'b1},  // R7
    {4'd2,  1'b0, 1'b0, 4'd0,  3'd2, 1'b1},  // R3 calibrate from rx
    {4'd0,  1'b0, 1'b0, 4'd11, 3'd3, 1'b1},  // R3 wait after 12 cycles
    {4'd4,  1'b0, 1'b0, 4'd0,  3'd5, 1'b1},  // R5 direct tx from wait
    {4'd0,  1'b0, 1'b1, 4'd0,  3'd3, 1'b1},  // R7 back to wait
    {4'd6,  1'b0, 1'b0, 4'd0,  3'd1, 1'b0},  // R8 rf off
    {4'd5,  1'b1, 1'b0, 4'd0,  3'd2, 1'b0},  // R6 clear channel, no cal
    {4'd0,  1'b0, 1'b0, 4'd11, 3'd5, 1'b1},  // R6 transmit after cal
    {4'd7,  1'b0, 1'b0, 4'd0,  3'd0, 1'b0},  // R8 osc off
    {4'd3,  1'b0, 1'b0, 4'd0,  3'd0, 1'b0}   // R2 rx on ignored while down
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] c, input logic cc, input logic dn);
    cmd_vld = 1'b1; cmd_code = c; cca_clear = cc; tx_done = dn;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_code = 4'd0; cca_clear = 1'b0; tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 xosc_pd", xosc_pd, 1);
    chk("R1 bias_pd", bias_pd, 1);
    chk("R1 enables", {rx_en, tx_en, synth_en, cal_valid}, 0);
    chk("R1 pulses", {flush_rx, flush_tx, ack_req, fifo_err}, 0);

    fifo_wr = 1'b1;
    #1 chk("R11 wr gated off", fifo_wr_ok, 0);
    @(negedge clk);
    fifo_wr = 1'b0;
    chk("R11 err set", fifo_err, 1);
    strobe(4'd8, 1'b0, 1'b0);
    chk("R9 flush ignored when down", flush_rx, 0);
    strobe(4'd10, 1'b0, 1'b0);
    chk("R10 ack ignored when down", ack_req, 0);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][13:10], VEC[i][9], VEC[i][8]);
      repeat (int'(VEC[i][7:4])) @(negedge clk);
      chk($sformatf("R5 table row %0d mode", i), mode, int'(VEC[i][3:1]));
      chk($sformatf("R3 table row %0d cal_valid", i), cal_valid, int'(VEC[i][0]));
    end

    strobe(4'd1, 1'b0, 1'b0);
    chk("R2 pd cleared", {xosc_pd, bias_pd}, 0);
    chk("R2 synth off in idle", synth_en, 0);
    chk("R11 err sticky", fifo_err, 1);
    fifo_rd = 1'b1;
    #1 chk("R11 rd passes", fifo_rd_ok, 1);
    @(negedge clk);
    fifo_rd = 1'b0;
    strobe(4'd8, 1'b0, 1'b0);
    chk("R9 flush rx pulse", {flush_rx, flush_tx}, 2);
    @(negedge clk);
    chk("R9 flush rx one cycle", flush_rx, 0);
    strobe(4'd9, 1'b0, 1'b0);
    chk("R9 flush tx pulse", {flush_rx, flush_tx}, 1);
    strobe(4'd11, 1'b0, 1'b0);
    chk("R10 ack pending", {ack_req, ack_pend}, 3);
    strobe(4'd10, 1'b0, 1'b0);
    chk("R10 ack clear", {ack_req, ack_pend}, 2);
    @(negedge clk);
    chk("R10 ack one cycle", ack_req, 0);
    strobe(4'd15, 1'b0, 1'b0);
    chk("R2 unused code", mode, 1);
    strobe(4'd3, 1'b0, 1'b0);
    chk("R4 rx enables", {rx_en, tx_en, synth_en}, 5);
    strobe(4'd3, 1'b0, 1'b0);
    chk("R4 rx on in rx", mode, 4);
    strobe(4'd0, 1'b0, 1'b1);
    chk("R7 done outside tx", mode, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule